// File: doc/BRIEF.md
# Privileged CSR access unit

This block carries out the control and status register instructions of a processor core: a plain read, a write that swaps a new value in, and a masked exchange that changes only the bits a mask selects. Each request brings a 14-bit register number, a source operand, a mask operand, an operation code and the privilege level the core is running at. One cycle later the unit returns the value bound for the destination register, together with flags for a privilege fault, an illegal instruction and a pipeline flush request.

The unit holds the storage for every defined register. There are nine plain writable registers, six read-only identification and configuration registers whose values are fixed by parameters, a bank of sixteen scratch registers and a bank of four address-window registers. Instruction decode, the actual pipeline flush and the side effects of individual registers (timers, translation tables) belong to the surrounding core.

Register map (hex numbers): current mode 000, previous mode 001, extension enable 002, exception config 003, exception status 004, return address 005, bad address 006, exception entry 007, address-space id 008. Read-only: misc info 010, bad instruction 011, processor id 012, configuration words 013 to 015. Scratch 040 + i (i = 0..15), address windows 100 + i (i = 0..3). Every other number is undefined.

Top module: `csr_unit`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one response: `rsp_done` is high in the following cycle and low in every cycle after an idle one, where `rsp_rdata` and all flags are zero; requests may follow one another on consecutive cycles.
- R2: A request with `req_priv` equal to 3 (user level) raises `rsp_priv_exc`, returns zero and changes no register, whatever the operation or register number.
- R3: A read (`req_op` 0) of a defined register returns its current value; a read of an undefined number returns zero.
- R4: A write (`req_op` 1) stores `req_wdata` and returns the value the register held before.
- R5: An exchange (`req_op` 2) stores `(req_wdata & req_mask) | (old & ~req_mask)` and returns the old value; a zero mask leaves the register unchanged.
- R6: A write or exchange to an undefined number is dropped, returns zero and raises no flag.
- R7: A write or exchange to a read-only register (010 to 015) raises `rsp_illegal`, returns zero and leaves the register at its parameter value, which reads return.
- R8: The sixteen scratch registers at 040 + i and the four window registers at 100 + i are stored independently of each other.
- R9: `rsp_flush` is raised for an accepted write or exchange to current mode (000), extension enable (002), exception status (004) or address-space id (008), and for no read and no other register.
- R10: Reset clears every writable register to zero and clears the response; read-only registers keep their parameter values.
- R11: Operation code 3 behaves as a read: it returns the register value and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 write, 2 exchange, 3 read |
| req_addr | input | AW | Register number |
| req_wdata | input | XLEN | Source operand |
| req_mask | input | XLEN | Exchange mask |
| req_priv | input | 2 | Privilege level, 3 is user |
| rsp_done | output | 1 | Response valid |
| rsp_rdata | output | XLEN | Value for the destination register |
| rsp_priv_exc | output | 1 | Privilege fault |
| rsp_illegal | output | 1 | Write to read-only register |
| rsp_flush | output | 1 | Flush request after a mode-changing write |

## Verification
The bench goes after the exchange merge with mixed and empty masks, where a unit that merged the wrong way round or returned the new value would corrupt the register or the destination. It writes to read-only and undefined numbers and then reads them back, catching a unit that stores into constants, traps on undefined numbers or returns stale data. User-level requests followed by kernel reads expose a unit that checks privilege after updating storage, and writes to the first and last scratch and window slots catch index decoding that aliases neighbours. A write followed at once by a read of the same register checks that the new value is visible on the next cycle, and a late reset checks that scratch banks are cleared while configuration constants are not.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam int IDX_W = 8;

    localparam int N_PLAIN = 9;
    localparam int N_CONST = 6;

    localparam int PLAIN_BASE   = 'h000;
    localparam int CONST_BASE   = 'h010;
    localparam int SCRATCH_BASE = 'h040;
    localparam int WINDOW_BASE  = 'h100;

    // plain registers whose update must flush the pipeline:
    // current mode (0), extension enable (2), exception status (4), address-space id (8)
    localparam logic [N_PLAIN-1:0] PLAIN_FLUSH_MASK = 9'b1_0001_0101;

    localparam logic [1:0] USER_PRIV = 2'b11;

    typedef enum logic [1:0] {
        CSR_OP_READ  = 2'd0,
        CSR_OP_WRITE = 2'd1,
        CSR_OP_XCHG  = 2'd2,
        CSR_OP_PEEK  = 2'd3
    } csr_op_e;

    typedef enum logic [2:0] {
        CLS_NONE    = 3'd0,
        CLS_CONST   = 3'd1,
        CLS_PLAIN   = 3'd2,
        CLS_SCRATCH = 3'd3,
        CLS_WINDOW  = 3'd4
    } csr_cls_e;

    typedef struct packed {
        csr_cls_e          cls;
        logic [IDX_W-1:0]  idx;
        logic              flush;
    } csr_sel_t;

    function automatic logic op_writes(csr_op_e op);
        return (op == CSR_OP_WRITE) || (op == CSR_OP_XCHG);
    endfunction

    function automatic logic cls_stored(csr_cls_e c);
        return (c == CLS_PLAIN) || (c == CLS_SCRATCH) || (c == CLS_WINDOW);
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
    import csr_pkg::*;
#(
    parameter int AW        = 14,
    parameter int N_SCRATCH = 16,
    parameter int N_WINDOW  = 4
) (
    input  logic [AW-1:0] addr,
    output csr_sel_t      sel
);

    logic [31:0] a32;

    always_comb begin
        a32 = 32'(addr);
        sel = '{cls: CLS_NONE, idx: '0, flush: 1'b0};
        if (a32 < 32'(PLAIN_BASE + N_PLAIN)) begin
            sel.cls = CLS_PLAIN;
            sel.idx = IDX_W'(a32 - 32'(PLAIN_BASE));
            for (int i = 0; i < N_PLAIN; i++) begin
                if (sel.idx == IDX_W'(i)) sel.flush = PLAIN_FLUSH_MASK[i];
            end
        end else if (a32 >= 32'(CONST_BASE) && a32 < 32'(CONST_BASE + N_CONST)) begin
            sel.cls = CLS_CONST;
            sel.idx = IDX_W'(a32 - 32'(CONST_BASE));
        end else if (a32 >= 32'(SCRATCH_BASE) && a32 < 32'(SCRATCH_BASE + N_SCRATCH)) begin
            sel.cls = CLS_SCRATCH;
            sel.idx = IDX_W'(a32 - 32'(SCRATCH_BASE));
        end else if (a32 >= 32'(WINDOW_BASE) && a32 < 32'(WINDOW_BASE + N_WINDOW)) begin
            sel.cls = CLS_WINDOW;
            sel.idx = IDX_W'(a32 - 32'(WINDOW_BASE));
        end
    end

endmodule

// File: rtl/csr_const_bank.sv
module csr_const_bank
    import csr_pkg::*;
#(
    parameter int                          XLEN   = 64,
    parameter logic [N_CONST*XLEN-1:0]     VALUES = '0
) (
    input  csr_sel_t          sel,
    output logic [XLEN-1:0]   rdata
);

    always_comb begin
        rdata = '0;
        if (sel.cls == CLS_CONST) begin
            for (int i = 0; i < N_CONST; i++) begin
                if (sel.idx == IDX_W'(i)) rdata = VALUES[i*XLEN +: XLEN];
            end
        end
    end

endmodule

// File: rtl/csr_store.sv
module csr_store
    import csr_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int N_SCRATCH = 16,
    parameter int N_WINDOW  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  csr_sel_t          sel,
    input  logic [XLEN-1:0]   wdata,
    output logic [XLEN-1:0]   rdata
);

    logic [XLEN-1:0] plain_q   [N_PLAIN];
    logic [XLEN-1:0] scratch_q [N_SCRATCH];
    logic [XLEN-1:0] window_q  [N_WINDOW];

    generate
        for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    plain_q[g] <= '0;
                else if (we && sel.cls == CLS_PLAIN && sel.idx == IDX_W'(g))
                    plain_q[g] <= wdata;
            end
        end
        for (genvar g = 0; g < N_SCRATCH; g++) begin : g_scratch
            always_ff @(posedge clk) begin
                if (rst)
                    scratch_q[g] <= '0;
                else if (we && sel.cls == CLS_SCRATCH && sel.idx == IDX_W'(g))
                    scratch_q[g] <= wdata;
            end
        end
        for (genvar g = 0; g < N_WINDOW; g++) begin : g_window
            always_ff @(posedge clk) begin
                if (rst)
                    window_q[g] <= '0;
                else if (we && sel.cls == CLS_WINDOW && sel.idx == IDX_W'(g))
                    window_q[g] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        case (sel.cls)
            CLS_PLAIN: begin
                for (int i = 0; i < N_PLAIN; i++)
                    if (sel.idx == IDX_W'(i)) rdata = plain_q[i];
            end
            CLS_SCRATCH: begin
                for (int i = 0; i < N_SCRATCH; i++)
                    if (sel.idx == IDX_W'(i)) rdata = scratch_q[i];
            end
            CLS_WINDOW: begin
                for (int i = 0; i < N_WINDOW; i++)
                    if (sel.idx == IDX_W'(i)) rdata = window_q[i];
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/csr_unit.sv
module csr_unit
    import csr_pkg::*;
#(
    parameter int          XLEN      = 64,
    parameter int          AW        = 14,
    parameter int          N_SCRATCH = 16,
    parameter int          N_WINDOW  = 4,
    parameter logic [63:0] RO_MISC   = 64'h0000_0000_0000_0A01,
    parameter logic [63:0] RO_BADI   = 64'h0000_0000_0000_0000,
    parameter logic [63:0] RO_CPUID  = 64'h0000_0000_0000_0005,
    parameter logic [63:0] RO_CFG1   = 64'h0000_0000_0000_3C10,
    parameter logic [63:0] RO_CFG2   = 64'h0000_0000_0000_1000,
    parameter logic [63:0] RO_CFG3   = 64'h0000_0000_0000_0208
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [AW-1:0]     req_addr,
    input  logic [XLEN-1:0]   req_wdata,
    input  logic [XLEN-1:0]   req_mask,
    input  logic [1:0]        req_priv,
    output logic              rsp_done,
    output logic [XLEN-1:0]   rsp_rdata,
    output logic              rsp_priv_exc,
    output logic              rsp_illegal,
    output logic              rsp_flush
);

    localparam logic [N_CONST*XLEN-1:0] CONST_VALUES = {
        XLEN'(RO_CFG3), XLEN'(RO_CFG2), XLEN'(RO_CFG1),
        XLEN'(RO_CPUID), XLEN'(RO_BADI), XLEN'(RO_MISC)
    };

    typedef struct packed {
        logic              done;
        logic [XLEN-1:0]   rdata;
        logic              priv_exc;
        logic              illegal;
        logic              flush;
    } csr_rsp_t;

    csr_sel_t          sel;
    csr_op_e           op;
    logic [XLEN-1:0]   store_rd;
    logic [XLEN-1:0]   const_rd;
    logic [XLEN-1:0]   cur_val;
    logic [XLEN-1:0]   next_val;
    logic              user_fault;
    logic              wants_write;
    logic              ro_fault;
    logic              store_we;
    csr_rsp_t          rsp_d;
    csr_rsp_t          rsp_q;

    csr_addr_decode #(
        .AW        (AW),
        .N_SCRATCH (N_SCRATCH),
        .N_WINDOW  (N_WINDOW)
    ) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    csr_const_bank #(
        .XLEN   (XLEN),
        .VALUES (CONST_VALUES)
    ) u_const (
        .sel   (sel),
        .rdata (const_rd)
    );

    csr_store #(
        .XLEN      (XLEN),
        .N_SCRATCH (N_SCRATCH),
        .N_WINDOW  (N_WINDOW)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (store_we),
        .sel   (sel),
        .wdata (next_val),
        .rdata (store_rd)
    );

    always_comb begin
        op          = csr_op_e'(req_op);
        wants_write = op_writes(op);
        user_fault  = req_valid && (req_priv == USER_PRIV);
        ro_fault    = req_valid && !user_fault && wants_write && (sel.cls == CLS_CONST);
        store_we    = req_valid && !user_fault && wants_write && cls_stored(sel.cls);

        if (sel.cls == CLS_CONST)
            cur_val = const_rd;
        else if (cls_stored(sel.cls))
            cur_val = store_rd;
        else
            cur_val = '0;

        if (op == CSR_OP_XCHG)
            next_val = (req_wdata & req_mask) | (cur_val & ~req_mask);
        else
            next_val = req_wdata;

        rsp_d          = '0;
        rsp_d.done     = req_valid;
        rsp_d.priv_exc = user_fault;
        rsp_d.illegal  = ro_fault;
        rsp_d.flush    = store_we && sel.flush;
        if (req_valid && !user_fault && !ro_fault)
            rsp_d.rdata = cur_val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign rsp_done     = rsp_q.done;
    assign rsp_rdata    = rsp_q.rdata;
    assign rsp_priv_exc = rsp_q.priv_exc;
    assign rsp_illegal  = rsp_q.illegal;
    assign rsp_flush    = rsp_q.flush;

endmodule

// File: rtl/csr_unit_checks.sv
module csr_unit_checks
    import csr_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int AW   = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [AW-1:0]    req_addr,
    input logic [1:0]       req_priv,
    input logic             rsp_done,
    input logic [XLEN-1:0]  rsp_rdata,
    input logic             rsp_priv_exc,
    input logic             rsp_illegal,
    input logic             rsp_flush
);

    logic ro_target;
    logic is_write_op;
    assign ro_target   = (32'(req_addr) >= 32'(CONST_BASE)) &&
                         (32'(req_addr) <  32'(CONST_BASE + N_CONST));
    assign is_write_op = (req_op == CSR_OP_WRITE) || (req_op == CSR_OP_XCHG);

    a_r1_done_follows_valid: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_done);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_done && rsp_rdata == '0 && !rsp_priv_exc && !rsp_illegal && !rsp_flush));

    a_r2_user_faults: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv == USER_PRIV) |=> (rsp_priv_exc && rsp_rdata == '0 && !rsp_flush));

    a_r7_ro_write_illegal: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv != USER_PRIV && is_write_op && ro_target) |=> (rsp_illegal && rsp_rdata == '0));

    a_r9_read_no_flush: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_write_op) |=> !rsp_flush);

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rsp_priv_exc, rsp_illegal, rsp_flush}));

endmodule

bind csr_unit csr_unit_checks #(.XLEN(XLEN), .AW(AW)) u_checks (.*);

// File: tb/csr_unit_bench.sv
`timescale 1ns/1ps
module csr_unit_bench;
    import csr_pkg::*;

    localparam logic [63:0] E_MISC  = 64'h0000_0000_0000_0A01;
    localparam logic [63:0] E_CPUID = 64'h0000_0000_0000_0005;
    localparam logic [63:0] E_CFG1  = 64'h0000_0000_0000_3C10;
    localparam logic [63:0] VA      = 64'h1111_2222_3333_4444;
    localparam logic [63:0] VB      = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] VMRG    = 64'h01FF_45FF_8900_CD00;
    localparam logic [63:0] ONES    = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [7:0]  rq;
        logic [1:0]  op;
        logic [13:0] addr;
        logic [63:0] wd;
        logic [63:0] mk;
        logic [1:0]  pv;
        logic [63:0] exp;
        logic [2:0]  fl;   // {priv_exc, illegal, flush}
    } vec_t;

    localparam int N_VEC = 39;
    localparam vec_t VECS [N_VEC] = '{
        '{8'd3,  2'd0, 14'h000, 64'h0, 64'h0, 2'd0, 64'h0, 3'b000},   // R3 reset value
        '{8'd9,  2'd1, 14'h000, VA,    64'h0, 2'd0, 64'h0, 3'b001},   // R9 mode write flushes
        '{8'd4,  2'd0, 14'h000, 64'h0, 64'h0, 2'd0, VA,    3'b000},   // R4 stored
        '{8'd4,  2'd1, 14'h001, VB,    64'h0, 2'd0, 64'h0, 3'b000},   // R4 no flush on prev mode
        '{8'd5,  2'd2, 14'h001, 64'hFFFF_FFFF_0000_0000, 64'h00FF_00FF_00FF_00FF, 2'd0, VB, 3'b000}, // R5
        '{8'd5,  2'd0, 14'h001, 64'h0, 64'h0, 2'd0, VMRG,  3'b000},   // R5 merged
        '{8'd5,  2'd2, 14'h001, ONES,  64'h0, 2'd0, VMRG,  3'b000},   // R5 empty mask
        '{8'd5,  2'd0, 14'h001, 64'h0, 64'h0, 2'd0, VMRG,  3'b000},   // R5 unchanged
        '{8'd8,  2'd1, 14'h040, 64'hAAAA, 64'h0, 2'd0, 64'h0, 3'b000}, // R8 first scratch
        '{8'd8,  2'd1, 14'h04F, 64'hBBBB, 64'h0, 2'd0, 64'h0, 3'b000}, // R8 last scratch
        '{8'd8,  2'd0, 14'h040, 64'h0, 64'h0, 2'd0, 64'hAAAA, 3'b000},
        '{8'd8,  2'd0, 14'h04F, 64'h0, 64'h0, 2'd0, 64'hBBBB, 3'b000},
        '{8'd8,  2'd0, 14'h041, 64'h0, 64'h0, 2'd0, 64'h0, 3'b000},
        '{8'd8,  2'd1, 14'h103, 64'hC0DE, 64'h0, 2'd0, 64'h0, 3'b000}, // R8 last window
        '{8'd8,  2'd0, 14'h100, 64'h0, 64'h0, 2'd0, 64'h0, 3'b000},
        '{8'd8,  2'd0, 14'h103, 64'h0, 64'h0, 2'd0, 64'hC0DE, 3'b000},
        '{8'd7,  2'd0, 14'h012, 64'h0, 64'h0, 2'd0, E_CPUID, 3'b000}, // R7 const read
        '{8'd7,  2'd1, 14'h012, 64'hFF, 64'h0, 2'd0, 64'h0, 3'b010},  // R7 trap
        '{8'd7,  2'd0, 14'h012, 64'h0, 64'h0, 2'd0, E_CPUID, 3'b000}, // R7 kept
        '{8'd7,  2'd2, 14'h013, ONES,  ONES,  2'd0, 64'h0, 3'b010},   // R7 xchg trap
        '{8'd7,  2'd0, 14'h013, 64'h0, 64'h0, 2'd0, E_CFG1, 3'b000},
        '{8'd7,  2'd0, 14'h010, 64'h0, 64'h0, 2'd0, E_MISC, 3'b000},
        '{8'd3,  2'd0, 14'h7FF, 64'h0, 64'h0, 2'd0, 64'h0, 3'b000},   // R3 undefined read
        '{8'd6,  2'd1, 14'h7FF, 64'h1234, 64'h0, 2'd0, 64'h0, 3'b000}, // R6
        '{8'd6,  2'd0, 14'h7FF, 64'h0, 64'h0, 2'd0, 64'h0, 3'b000},
        '{8'd6,  2'd2, 14'h050, ONES,  ONES,  2'd0, 64'h0, 3'b000},   // R6 past scratch bank
        '{8'd2,  2'd1, 14'h000, 64'h99, 64'h0, 2'd3, 64'h0, 3'b100},  // R2 user write
        '{8'd2,  2'd0, 14'h000, 64'h0, 64'h0, 2'd0, VA,    3'b000},   // R2 unchanged
        '{8'd2,  2'd0, 14'h001, 64'h0, 64'h0, 2'd3, 64'h0, 3'b100},   // R2 user read
        '{8'd9,  2'd2, 14'h008, 64'h3F, 64'hFF, 2'd0, 64'h0, 3'b001}, // R9 asid xchg
        '{8'd9,  2'd0, 14'h008, 64'h0, 64'h0, 2'd0, 64'h3F, 3'b000},  // R9 read no flush
        '{8'd9,  2'd1, 14'h004, 64'h1, 64'h0, 2'd0, 64'h0, 3'b001},   // R9 exc status
        '{8'd9,  2'd1, 14'h003, 64'h2, 64'h0, 2'd0, 64'h0, 3'b000},   // R9 exc config
        '{8'd9,  2'd1, 14'h002, 64'h7, 64'h0, 2'd1, 64'h0, 3'b001},   // R9 ext enable
        '{8'd11, 2'd3, 14'h000, 64'hFFFF, 64'h0, 2'd0, VA, 3'b000},   // R11
        '{8'd11, 2'd0, 14'h000, 64'h0, 64'h0, 2'd0, VA,    3'b000},   // R11 unchanged
        '{8'd2,  2'd2, 14'h040, ONES,  ONES,  2'd3, 64'h0, 3'b100},   // R2 user xchg
        '{8'd2,  2'd0, 14'h040, 64'h0, 64'h0, 2'd0, 64'hAAAA, 3'b000},
        '{8'd7,  2'd1, 14'h015, 64'h1, 64'h0, 2'd2, 64'h0, 3'b010}    // R7 last const
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [13:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_mask = '0;
    logic [1:0]  req_priv = '0;
    logic        rsp_done;
    logic [63:0] rsp_rdata;
    logic        rsp_priv_exc;
    logic        rsp_illegal;
    logic        rsp_flush;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    csr_unit u_csr_unit (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_op (req_op),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_mask (req_mask),
        .req_priv (req_priv), .rsp_done (rsp_done), .rsp_rdata (rsp_rdata),
        .rsp_priv_exc (rsp_priv_exc), .rsp_illegal (rsp_illegal), .rsp_flush (rsp_flush)
    );

    task automatic check_rsp(string tag, logic [63:0] exp_rd, logic [3:0] exp_fl);
        logic [3:0] act_fl;
        act_fl = {rsp_done, rsp_priv_exc, rsp_illegal, rsp_flush};
        n_checks++;
        if (rsp_rdata !== exp_rd || act_fl !== exp_fl) begin
            n_fail++;
            $display("FAIL %s: actual rdata=%h flags=%b expected rdata=%h flags=%b",
                     tag, rsp_rdata, act_fl, exp_rd, exp_fl);
        end
    endtask

    task automatic drive(logic [1:0] op, logic [13:0] addr, logic [63:0] wd,
                         logic [63:0] mk, logic [1:0] pv);
        req_valid = 1'b1; req_op = op; req_addr = addr;
        req_wdata = wd; req_mask = mk; req_priv = pv;
    endtask

    task automatic issue(logic [1:0] op, logic [13:0] addr, logic [63:0] wd,
                         logic [63:0] mk, logic [1:0] pv);
        @(negedge clk);
        drive(op, addr, wd, mk, pv);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk); #1;
        check_rsp("R10 response clear after reset", 64'h0, 4'b0000);

        for (int i = 0; i < N_VEC; i++) begin
            issue(VECS[i].op, VECS[i].addr, VECS[i].wd, VECS[i].mk, VECS[i].pv);
            check_rsp($sformatf("R%0d vector %0d", VECS[i].rq, i), VECS[i].exp, {1'b1, VECS[i].fl});
        end

        // R1: idle cycle after a response is quiet
        issue(2'd0, 14'h000, 64'h0, 64'h0, 2'd0);
        @(posedge clk); #1;
        check_rsp("R1 idle cycle", 64'h0, 4'b0000);

        // R1: back-to-back write then read of return address
        @(negedge clk);
        drive(2'd1, 14'h005, 64'h77, 64'h0, 2'd0);
        @(negedge clk);
        check_rsp("R1 back-to-back write", 64'h0, 4'b1000);
        drive(2'd0, 14'h005, 64'h0, 64'h0, 2'd0);
        @(negedge clk);
        check_rsp("R1 back-to-back read", 64'h77, 4'b1000);
        req_valid = 1'b0;

        // R10: late reset clears writable registers, constants stay
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        issue(2'd0, 14'h000, 64'h0, 64'h0, 2'd0);
        check_rsp("R10 mode cleared", 64'h0, 4'b1000);
        issue(2'd0, 14'h04F, 64'h0, 64'h0, 2'd0);
        check_rsp("R10 scratch cleared", 64'h0, 4'b1000);
        issue(2'd0, 14'h103, 64'h0, 64'h0, 2'd0);
        check_rsp("R10 window cleared", 64'h0, 4'b1000);
        issue(2'd0, 14'h012, 64'h0, 64'h0, 2'd0);
        check_rsp("R10 constant kept", E_CPUID, 4'b1000);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule